// File: doc/BRIEF.md
# Clock Enable Divider and Source Selector

This block turns several clock sources into two clock enables that all run in a single fast clock domain. A peripheral enable, `per_en`, marks each internal clock period. A CPU enable, `cpu_en`, is a thinned copy of that enable. No gated or derived clock is built in logic: every source arrives as a one-cycle tick on a fast-clock input, and both results leave as one-cycle enables.

The block has three sources:
- **Reference path.** An oscillator-derived reference goes through an optional halving stage, which gives even duty, and then through a fixed divide-by-16 path. This path is used while the external multiplier is off.
- **Multiplier path.** When the multiplier is on, its output ticks are divided by a programmable post ratio of 1 to 7.
- **Alternate path.** A low-frequency alternate tick can replace both of the other paths.

A CPU prescaler divides the internal enable by 1 to 8 for the CPU only, so peripherals keep the full internal rate.

A small write port sets the ratios, the selects and the multiplier factor code. The block drives the factor code to the external multiplier together with its enable. It can also request that the main oscillator be stopped once running from the alternate source. A new setting takes effect only when the current period ends, so no enable interval is ever cut short.

Top module: `clk_enable_gen`

## Requirements
- R1: After reset, `per_en`, `cpu_en`, `osc_off_req`, `mul_en` and `mul_factor` are all 0. The defaults are: multiplier off, halver on, reference path, post code 0, CPU code 0. In this state `per_en` pulses once per 32 reference ticks.
- R2: With the halver off (ctrl bit 1 = 0) and the multiplier off, `per_en` pulses once per 16 reference ticks.
- R3: With the multiplier on (ctrl bit 0 = 1), `per_en` pulses once per N multiplier ticks. N is the post code (register address 1, bits 2:0), and code 0 counts as N = 1.
- R4: With the alternate source selected (ctrl bit 2 = 1), every alternate tick gives a `per_en` pulse, regardless of the other selects.
- R5: `cpu_en` pulses on every (C+1)-th `per_en` pulse, in the same cycle, where C is the CPU code (address 2, bits 2:0). `cpu_en` is never high without `per_en`.
- R6: A write to the control or post-divider register does not alter the internal period in progress. The new setting applies from the period that starts after the next `per_en`.
- R7: A change to the CPU code applies only after the current CPU period ends with a `cpu_en` pulse.
- R8: `osc_off_req` rises one cycle after all three of these hold: the stop bit (ctrl bit 3) is set, the alternate source is selected, and the alternate source is already active. It stays 0 while the switch-over is pending.
- R9: `mul_en` and `mul_factor` show ctrl bit 0 and ctrl bits 5:4 from the cycle after the write. Factor codes 0, 1, 2 and 3 request multiplication by 6, 8, 10 and 14.
- R10: A write to address 3 has no effect on any output.
- R11: `per_en` goes high exactly one cycle after the fast-clock edge that samples the tick completing a period. It lasts one cycle per such tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle tick per reference (oscillator) edge |
| mul_tick | input | 1 | One-cycle tick per external multiplier output edge |
| alt_tick | input | 1 | One-cycle tick per alternate low-frequency edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 control, 1 post divider, 2 CPU prescaler |
| wr_data | input | DATA_W | Write data |
| per_en | output | 1 | Peripheral (internal) clock enable |
| cpu_en | output | 1 | CPU clock enable |
| mul_en | output | 1 | Enable request to the external multiplier |
| mul_factor | output | 2 | Multiplication factor code to the external multiplier |
| osc_off_req | output | 1 | Request to stop the main oscillator |

## Verification
Inputs change on the falling clock edge, and results are read on the next falling edge or later.

Timing of each result:
- **`per_en` and `cpu_en`:** both are registered once, so they are due on the first falling edge after the rising edge that takes the tick completing a period.
- **`mul_en` and `mul_factor`:** due on the falling edge right after the write edge.
- **`osc_off_req`:** needs one more register stage on top of the switch-over, so the bench reads it one full cycle later.

Each table vector first drives all sources until a `cpu_en` appears, so the new settings are loaded and every counter starts from zero. The bench then counts ticks of the chosen source between pulses.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    // Width of the post-divider and CPU prescaler codes
    localparam int unsigned CKG_DIV_W = 3;
    // Width of the multiplier factor code
    localparam int unsigned CKG_MUL_W = 2;

    // Register addresses
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_POST = 1;
    localparam int unsigned ADDR_CPU  = 2;

    // Control register bit positions
    localparam int unsigned CTL_MUL_ON   = 0;
    localparam int unsigned CTL_HALF     = 1;
    localparam int unsigned CTL_ALT      = 2;
    localparam int unsigned CTL_OSC_OFF  = 3;
    localparam int unsigned CTL_MCODE_LO = 4;

    // Settings that shape the internal enable
    typedef struct packed {
        logic                 mul_on;
        logic                 half_en;
        logic                 alt_sel;
        logic [CKG_DIV_W-1:0] post_code;
    } path_cfg_t;

    // Full set of programmed values
    typedef struct packed {
        path_cfg_t            path;
        logic                 osc_off;
        logic [CKG_MUL_W-1:0] mul_code;
        logic [CKG_DIV_W-1:0] cpu_code;
    } cfg_t;

    localparam path_cfg_t PATH_RESET = '{
        mul_on:    1'b0,
        half_en:   1'b1,
        alt_sel:   1'b0,
        post_code: '0
    };

    localparam cfg_t CFG_RESET = '{
        path:     PATH_RESET,
        osc_off:  1'b0,
        mul_code: '0,
        cpu_code: '0
    };

endpackage

// File: rtl/ckg_cfg_regs.sv
module ckg_cfg_regs
    import ckg_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alt_active,
    output cfg_t              cfg,
    output logic              osc_off_req
);

    typedef struct packed {
        cfg_t cfg;
        logic osc_req;
    } regs_t;

    regs_t s_d, s_q;

    // Data bits above the control field are not decoded
    logic wr_hi_unused;
    assign wr_hi_unused = ^wr_data[DATA_W-1:CTL_MCODE_LO+CKG_MUL_W];

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
                s_d.cfg.path.mul_on  = wr_data[CTL_MUL_ON];
                s_d.cfg.path.half_en = wr_data[CTL_HALF];
                s_d.cfg.path.alt_sel = wr_data[CTL_ALT];
                s_d.cfg.osc_off      = wr_data[CTL_OSC_OFF];
                s_d.cfg.mul_code     = wr_data[CTL_MCODE_LO +: CKG_MUL_W];
            end else if (wr_addr == ADDR_W'(ADDR_POST)) begin
                s_d.cfg.path.post_code = wr_data[CKG_DIV_W-1:0];
            end else if (wr_addr == ADDR_W'(ADDR_CPU)) begin
                s_d.cfg.cpu_code = wr_data[CKG_DIV_W-1:0];
            end
        end
        // Stop request only while the alternate source is both requested and running
        s_d.osc_req = s_q.cfg.osc_off && s_q.cfg.path.alt_sel && alt_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cfg: CFG_RESET, osc_req: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg         = s_q.cfg;
    assign osc_off_req = s_q.osc_req;

endmodule

// File: rtl/ckg_src_path.sv
module ckg_src_path
    import ckg_pkg::*;
#(
    parameter int unsigned BYP_DIV = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_tick,
    input  logic      mul_tick,
    input  logic      alt_tick,
    input  path_cfg_t pend,
    output logic      src_tick,
    output logic      per_en,
    output logic      alt_active
);

    localparam int unsigned BYP_W = (BYP_DIV > 1) ? $clog2(BYP_DIV) : 1;
    localparam logic [BYP_W-1:0] BYP_LAST = BYP_W'(BYP_DIV - 1);

    typedef struct packed {
        path_cfg_t            act;
        logic                 half_ph;
        logic [BYP_W-1:0]     byp_cnt;
        logic [CKG_DIV_W-1:0] pd_cnt;
        logic                 per_en;
    } path_t;

    path_t s_d, s_q;

    logic                 clk2_tick;
    logic                 byp_tick;
    logic                 pd_tick;
    logic [CKG_DIV_W-1:0] pd_last;

    always_comb begin
        // Halving stage: pass every second reference tick when enabled
        clk2_tick = ref_tick && (!s_q.act.half_en || s_q.half_ph);
        byp_tick  = clk2_tick && (s_q.byp_cnt == BYP_LAST);
        // Post divider: code 0 behaves as ratio 1
        pd_last   = (s_q.act.post_code == '0) ? '0 : s_q.act.post_code - 1'b1;
        pd_tick   = mul_tick && (s_q.pd_cnt == pd_last);

        if (s_q.act.alt_sel) begin
            src_tick = alt_tick;
        end else if (s_q.act.mul_on) begin
            src_tick = pd_tick;
        end else begin
            src_tick = byp_tick;
        end

        s_d        = s_q;
        s_d.per_en = src_tick;
        if (ref_tick && s_q.act.half_en) begin
            s_d.half_ph = !s_q.half_ph;
        end
        if (clk2_tick) begin
            s_d.byp_cnt = s_q.byp_cnt + 1'b1;
        end
        if (mul_tick) begin
            s_d.pd_cnt = s_q.pd_cnt + 1'b1;
        end
        // End of an internal period: adopt new settings, restart all counters
        if (src_tick) begin
            s_d.act     = pend;
            s_d.half_ph = 1'b0;
            s_d.byp_cnt = '0;
            s_d.pd_cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{act: PATH_RESET, half_ph: 1'b0, byp_cnt: '0, pd_cnt: '0, per_en: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign per_en     = s_q.per_en;
    assign alt_active = s_q.act.alt_sel;

endmodule

// File: rtl/ckg_cpu_presc.sv
module ckg_cpu_presc
    import ckg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_tick,
    input  logic [CKG_DIV_W-1:0] code_pend,
    output logic                 cpu_en
);

    typedef struct packed {
        logic [CKG_DIV_W-1:0] act;
        logic [CKG_DIV_W-1:0] cnt;
        logic                 en;
    } presc_t;

    presc_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.en = 1'b0;
        if (src_tick) begin
            if (s_q.cnt == s_q.act) begin
                // CPU period complete: emit and take the new ratio
                s_d.en  = 1'b1;
                s_d.cnt = '0;
                s_d.act = code_pend;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{act: '0, cnt: '0, en: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_en = s_q.en;

endmodule

// File: rtl/clk_enable_gen.sv
module clk_enable_gen
    import ckg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned BYP_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              mul_tick,
    input  logic              alt_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              per_en,
    output logic              cpu_en,
    output logic              mul_en,
    output logic [1:0]        mul_factor,
    output logic              osc_off_req
);

    cfg_t cfg;
    logic alt_active;
    logic src_tick;

    ckg_cfg_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .alt_active (alt_active),
        .cfg        (cfg),
        .osc_off_req(osc_off_req)
    );

    ckg_src_path #(
        .BYP_DIV(BYP_DIV)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .mul_tick  (mul_tick),
        .alt_tick  (alt_tick),
        .pend      (cfg.path),
        .src_tick  (src_tick),
        .per_en    (per_en),
        .alt_active(alt_active)
    );

    ckg_cpu_presc u_cpu (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .code_pend(cfg.cpu_code),
        .cpu_en   (cpu_en)
    );

    // Multiplier controls follow the programmed values directly
    assign mul_en     = cfg.path.mul_on;
    assign mul_factor = cfg.mul_code;

endmodule

// File: rtl/ckg_checker.sv
module ckg_checker #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_tick,
    input logic              mul_tick,
    input logic              alt_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              per_en,
    input logic              cpu_en,
    input logic              mul_en,
    input logic [1:0]        mul_factor,
    input logic              osc_off_req,
    input logic              alt_active
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!per_en && !cpu_en && !osc_off_req));

    p_alt_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_active && alt_tick) |=> per_en);

    p_cpu_sub_per_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> per_en);

    p_osc_needs_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off_req |-> $past(alt_active));

    p_mul_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(0)) |=>
            (mul_en == $past(wr_data[0]) && mul_factor == $past(wr_data[5:4])));

    p_addr3_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(3)) |=> ($stable(mul_en) && $stable(mul_factor)));

    p_per_from_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> $past(ref_tick || mul_tick || alt_tick));

endmodule

bind clk_enable_gen ckg_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick),
    .mul_tick   (mul_tick),
    .alt_tick   (alt_tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .per_en     (per_en),
    .cpu_en     (cpu_en),
    .mul_en     (mul_en),
    .mul_factor (mul_factor),
    .osc_off_req(osc_off_req),
    .alt_active (alt_active)
);

// File: tb/clk_enable_gen_tb.sv
module clk_enable_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       mul_tick = 1'b0;
    logic       alt_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       per_en, cpu_en, mul_en, osc_off_req;
    logic [1:0] mul_factor;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = !clk;

    clk_enable_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mul_tick(mul_tick),
        .alt_tick(alt_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .per_en(per_en), .cpu_en(cpu_en), .mul_en(mul_en), .mul_factor(mul_factor),
        .osc_off_req(osc_off_req)
    );

    typedef struct packed {
        logic [7:0] ctrl;
        logic [2:0] post;
        logic [2:0] cpu;
        logic [1:0] src;   // 0 reference, 1 multiplier, 2 alternate
        logic [7:0] per;   // expected source ticks per per_en
        logic [3:0] cr;    // expected per_en pulses per cpu_en
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'h02, 3'd0, 3'd0, 2'd0, 8'd32, 4'd1},
        '{8'h00, 3'd0, 3'd1, 2'd0, 8'd16, 4'd2},
        '{8'h03, 3'd3, 3'd0, 2'd1, 8'd3,  4'd1},
        '{8'h03, 3'd0, 3'd2, 2'd1, 8'd1,  4'd3},
        '{8'h13, 3'd7, 3'd7, 2'd1, 8'd7,  4'd8},
        '{8'h06, 3'd5, 3'd3, 2'd2, 8'd1,  4'd4},
        '{8'h05, 3'd1, 3'd0, 2'd2, 8'd1,  4'd1},
        '{8'h01, 3'd5, 3'd1, 2'd1, 8'd5,  4'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One tick on the masked sources; per/cpu read on the falling edge after the sampling edge
    task automatic pulse(input logic [2:0] m, output logic p, output logic c);
        @(negedge clk);
        ref_tick = m[0]; mul_tick = m[1]; alt_tick = m[2];
        @(negedge clk);
        p = per_en; c = cpu_en;
        ref_tick = 1'b0; mul_tick = 1'b0; alt_tick = 1'b0;
        @(negedge clk);
        chk(per_en == 1'b0, "R11", int'(per_en), 0);
    endtask

    // Drive all sources until a cpu_en: new settings loaded, counters restarted
    task automatic sync_all();
        logic p, c;
        for (int i = 0; i < 1000; i++) begin
            pulse(3'b111, p, c);
            if (c) break;
        end
    endtask

    // Count ticks on masked sources until per_en; returns count and cpu_en state
    task automatic count_to_per(input logic [2:0] m, output int n, output logic c);
        logic p;
        n = 0; c = 1'b0;
        for (int i = 0; i < 64; i++) begin
            pulse(m, p, c);
            n++;
            if (p) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        logic c, p;
        string tag;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(per_en == 0 && cpu_en == 0 && osc_off_req == 0, "R1", int'({per_en, cpu_en, osc_off_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(per_en == 0 && cpu_en == 0 && osc_off_req == 0, "R1", int'({per_en, cpu_en, osc_off_req}), 0);
        chk(mul_en == 0 && mul_factor == 0, "R1", int'({mul_en, mul_factor}), 0);
        count_to_per(3'b001, n, c);
        chk(n == 32, "R1", n, 32);
        chk(c == 1'b1, "R5", int'(c), 1);

        // Table of vectors
        for (int v = 0; v < NVEC; v++) begin
            wr(2'd0, VECS[v].ctrl);
            wr(2'd1, {5'd0, VECS[v].post});
            wr(2'd2, {5'd0, VECS[v].cpu});
            sync_all();
            tag = (VECS[v].src == 2'd2) ? "R4" : (VECS[v].src == 2'd1) ? "R3" :
                  (VECS[v].ctrl[1] ? "R1" : "R2");
            for (int k = 1; k <= int'(VECS[v].cr); k++) begin
                count_to_per(3'b001 << VECS[v].src, n, c);
                chk(n == int'(VECS[v].per), tag, n, int'(VECS[v].per));
                chk(c == (k == int'(VECS[v].cr)), "R5", int'(c), int'(k == int'(VECS[v].cr)));
            end
        end

        // R6: change ratio mid-period
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) pulse(3'b001, p, c);
        wr(2'd0, 8'h00);
        count_to_per(3'b001, n, c);
        chk(n == 22, "R6", n, 22);
        count_to_per(3'b001, n, c);
        chk(n == 16, "R6", n, 16);

        // R7: CPU code change mid CPU period
        wr(2'd0, 8'h04);
        wr(2'd2, 8'd3);
        sync_all();
        pulse(3'b100, p, c);
        chk(p == 1 && c == 0, "R7", int'({p, c}), 2);
        wr(2'd2, 8'd0);
        pulse(3'b100, p, c);
        chk(c == 0, "R7", int'(c), 0);
        pulse(3'b100, p, c);
        chk(c == 0, "R7", int'(c), 0);
        pulse(3'b100, p, c);
        chk(c == 1, "R7", int'(c), 1);
        pulse(3'b100, p, c);
        chk(c == 1, "R7", int'(c), 1);

        // R8: oscillator stop request
        chk(osc_off_req == 0, "R8", int'(osc_off_req), 0);
        wr(2'd0, 8'h02);
        sync_all();
        wr(2'd0, 8'h0E);
        repeat (2) @(negedge clk);
        chk(osc_off_req == 0, "R8", int'(osc_off_req), 0);
        count_to_per(3'b001, n, c);
        chk(n == 32, "R8", n, 32);
        chk(osc_off_req == 1, "R8", int'(osc_off_req), 1);
        wr(2'd0, 8'h06);
        @(negedge clk);
        chk(osc_off_req == 0, "R8", int'(osc_off_req), 0);

        // R9: multiplier controls follow the write
        wr(2'd0, 8'h31);
        chk(mul_en == 1 && mul_factor == 2'd3, "R9", int'({mul_en, mul_factor}), 7);
        wr(2'd0, 8'h24);
        chk(mul_en == 0 && mul_factor == 2'd2, "R9", int'({mul_en, mul_factor}), 2);

        // R10: address 3 ignored
        sync_all();
        wr(2'd3, 8'hFF);
        @(negedge clk);
        chk(mul_en == 0 && mul_factor == 2'd2 && osc_off_req == 0, "R10",
            int'({mul_en, mul_factor, osc_off_req}), 4);
        pulse(3'b100, p, c);
        chk(p == 1 && c == 1, "R10", int'({p, c}), 3);

        finish_run();
    end

endmodule